// File: doc/BRIEF.md
# Signed-Digit Stage Alignment and Weighted Summation

This block sits behind an eight-stage converter that resolves 1.5 bits per stage. Each stage delivers one signed digit (-1, 0 or +1) as a 2-bit code. The most significant stage resolves a sample first, and every later stage produces its digit for that same sample one clock after the stage ahead of it. Because of this skew, the digits of one sample arrive at the block spread over eight consecutive clocks, with the most significant digit first.

The block gives each stage input its own register chain. Stage k gets (8 - k) registers, so all eight digits of one sample reach the adder in the same cycle. It then decodes the digits, weights each digit by its binary position, and sums them in a parallel adder. It adds a bias of 256 and registers a 9-bit unsigned code. Each stage has its own valid bit, which travels next to its digit. The output is marked valid only when all eight aligned digits are valid, which means they form a complete sample. The block takes a new sample on every clock.

Top module: `rsd_align_sum`

## Requirements
- R1: Stage codes decode as 2'b00 = -1, 2'b01 = 0 and 2'b10 = +1. For a valid sample, res_o equals 256 plus the weighted digit sum.
- R2: The digit of stage k has weight 2^(7-k). Stage 0 sits in bits [1:0] of stage_code_i and carries the most significant digit. Stage k sits in bits [2k+1:2k].
- R3: The digit of stage k for a sample is presented k clocks after the stage-0 digit. The result and vld_o for that sample are visible after the eighth rising edge that follows the edge capturing the stage-0 digit.
- R4: The output code stays within 1 to 511. All stages at +1 give 511, all at -1 give 1, and all at 0 give 256.
- R5: A new sample may start on every clock. Back-to-back samples produce independent results on consecutive cycles.
- R6: vld_o is high for a sample only if stage_vld_i[k] was high with the stage-k digit of that sample, for every k.
- R7: Code 2'b11 on any stage of a valid sample raises err_o with that sample's result. The illegal digit counts as 0 in the sum.
- R8: A synchronous reset clears every alignment register and the output registers. After reset, res_o = 0, vld_o = 0 and err_o = 0, and samples that were in flight never appear at the output.
- R9: err_o is never high while vld_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous reset, active high |
| stage_code_i | input | 16 | Stage digit codes, stage k in bits [2k+1:2k] |
| stage_vld_i | input | 8 | Per-stage valid, bit k goes with the stage-k code |
| res_o | output | 9 | Biased unsigned result |
| vld_o | output | 1 | Result belongs to one complete sample |
| err_o | output | 1 | An illegal code was seen in this sample |

## Verification
A chain of the wrong length, or one that is misordered, puts digits of neighbouring samples into one sum. Under a random stream, this corrupts res_o on the first sample whose neighbours differ, and the corruption shows exactly nine edges after the sample enters. A lost valid bit shows at the same cycle as vld_o staying low for a sample that was fully presented. Single-digit samples, one per stage, tie each weight to its bit of res_o. A reset in the middle of a full stream shows at once whether any in-flight sample survives.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
   localparam int CODE_W = 2;

   localparam logic [CODE_W-1:0] CODE_NEG  = 2'b00;
   localparam logic [CODE_W-1:0] CODE_ZERO = 2'b01;
   localparam logic [CODE_W-1:0] CODE_POS  = 2'b10;
   localparam logic [CODE_W-1:0] CODE_BAD  = 2'b11;

   typedef struct packed {
      logic              vld;
      logic [CODE_W-1:0] code;
   } stage_word_t;

   localparam stage_word_t STAGE_IDLE = '{vld: 1'b0, code: CODE_ZERO};
endpackage

// File: rtl/rsd_skew_line.sv
module rsd_skew_line
   import rsd_pkg::*;
#(
   parameter int DEPTH = 1
) (
   input  logic        clk,
   input  logic        rst,
   input  stage_word_t d_i,
   output stage_word_t q_o
);
   if (DEPTH < 1) begin : g_depth_chk
      $error("rsd_skew_line: DEPTH must be at least 1");
   end

   stage_word_t pipe [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) pipe[i] <= STAGE_IDLE;
      end else begin
         pipe[0] <= d_i;
         for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q_o = pipe[DEPTH-1];
endmodule

// File: rtl/rsd_digit_decode.sv
module rsd_digit_decode
   import rsd_pkg::*;
(
   input  logic [CODE_W-1:0] code_i,
   output logic signed [1:0] dig_o,
   output logic              bad_o
);
   always_comb begin
      bad_o = 1'b0;
      unique case (code_i)
         CODE_NEG:  dig_o = -2'sd1;
         CODE_POS:  dig_o =  2'sd1;
         CODE_ZERO: dig_o =  2'sd0;
         default: begin
            dig_o = 2'sd0;
            bad_o = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/rsd_weighted_sum.sv
module rsd_weighted_sum #(
   parameter int NSTAGE   = 8,
   parameter bit TREE_ADD = 1'b1,
   localparam int OUT_W   = NSTAGE + 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [2*NSTAGE-1:0]  dig_i,
   input  logic                 all_vld_i,
   input  logic                 any_bad_i,
   output logic [OUT_W-1:0]     res_o,
   output logic                 vld_o,
   output logic                 err_o
);
   localparam int SUM_W = NSTAGE + 2;
   localparam int NNODE = 2 * NSTAGE - 1;
   localparam logic signed [SUM_W-1:0] BIAS = SUM_W'(2 ** NSTAGE);
   localparam logic signed [SUM_W-1:0] MAXC = SUM_W'(2 ** OUT_W - 1);

   logic signed [SUM_W-1:0] term [NSTAGE];
   logic signed [SUM_W-1:0] sum_c;
   logic signed [SUM_W-1:0] biased_c;
   logic [OUT_W-1:0]        clip_c;

   // sign-extend each digit and shift it to its binary position
   always_comb begin
      for (int k = 0; k < NSTAGE; k++) begin
         term[k] = {{(SUM_W-2){dig_i[2*k+1]}}, dig_i[2*k +: 2]} <<< (NSTAGE - 1 - k);
      end
   end

   if (TREE_ADD) begin : g_tree
      logic signed [SUM_W-1:0] node [NNODE];
      always_comb begin
         for (int k = 0; k < NSTAGE; k++) node[NSTAGE-1+k] = term[k];
         for (int i = NSTAGE - 2; i >= 0; i--) node[i] = node[2*i+1] + node[2*i+2];
         sum_c = node[0];
      end
   end else begin : g_chain
      always_comb begin
         sum_c = '0;
         for (int k = 0; k < NSTAGE; k++) sum_c = sum_c + term[k];
      end
   end

   always_comb begin
      biased_c = sum_c + BIAS;
      if (biased_c < 0)         clip_c = '0;
      else if (biased_c > MAXC) clip_c = MAXC[OUT_W-1:0];
      else                      clip_c = biased_c[OUT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         res_o <= '0;
         vld_o <= 1'b0;
         err_o <= 1'b0;
      end else begin
         res_o <= clip_c;
         vld_o <= all_vld_i;
         err_o <= all_vld_i & any_bad_i;
      end
   end

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (!vld_o && !err_o && res_o == '0)); // R8
   AST_OUT_RANGE: assert property (@(posedge clk) disable iff (rst) vld_o |-> (res_o != '0)); // R4
   AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst) err_o |-> vld_o); // R9
endmodule

// File: rtl/rsd_align_sum.sv
module rsd_align_sum
   import rsd_pkg::*;
#(
   parameter int NSTAGE   = 8,
   parameter bit TREE_ADD = 1'b1,
   localparam int OUT_W   = NSTAGE + 1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [CODE_W*NSTAGE-1:0]   stage_code_i,
   input  logic [NSTAGE-1:0]          stage_vld_i,
   output logic [OUT_W-1:0]           res_o,
   output logic                       vld_o,
   output logic                       err_o
);
   if (NSTAGE < 2 || NSTAGE > 24) begin : g_nstage_chk
      $error("rsd_align_sum: NSTAGE must lie in 2..24");
   end

   stage_word_t         aligned [NSTAGE];
   logic [2*NSTAGE-1:0] dig_flat;
   logic [NSTAGE-1:0]   bad_vec;
   logic [NSTAGE-1:0]   vld_vec;

   for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
      stage_word_t  in_w;
      logic signed [1:0] dig_k;

      assign in_w.vld  = stage_vld_i[k];
      assign in_w.code = stage_code_i[CODE_W*k +: CODE_W];

      // stage k resolves k clocks late, so it needs k fewer registers
      rsd_skew_line #(.DEPTH(NSTAGE - k)) u_line (
         .clk (clk),
         .rst (rst),
         .d_i (in_w),
         .q_o (aligned[k])
      );

      rsd_digit_decode u_dec (
         .code_i (aligned[k].code),
         .dig_o  (dig_k),
         .bad_o  (bad_vec[k])
      );

      assign dig_flat[2*k +: 2] = dig_k;
      assign vld_vec[k]         = aligned[k].vld;
   end

   rsd_weighted_sum #(.NSTAGE(NSTAGE), .TREE_ADD(TREE_ADD)) u_sum (
      .clk       (clk),
      .rst       (rst),
      .dig_i     (dig_flat),
      .all_vld_i (&vld_vec),
      .any_bad_i (|bad_vec),
      .res_o     (res_o),
      .vld_o     (vld_o),
      .err_o     (err_o)
   );

   // the least significant digit alone sets the parity of the result
   AST_LSB_TRACK: assert property (@(posedge clk) disable iff (rst) (vld_o && !err_o) |-> (res_o[0] == $past(aligned[NSTAGE-1].code != CODE_ZERO))); // R2
endmodule

// File: tb/rsd_align_sum_tb.sv
module rsd_align_sum_tb;
   localparam int N  = 8;
   localparam int NS = 400;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [2*N-1:0] stage_code;
   logic [N-1:0] stage_vld;
   logic [N:0]   res;
   logic         vld, err;

   int checks = 0;
   int errors = 0;

   logic [1:0] code_a [NS][N];
   logic       sv_a   [NS][N];
   string      tag_a  [NS];

   always #5 clk = ~clk;

   rsd_align_sum u_dut (
      .clk (clk), .rst (rst), .stage_code_i (stage_code), .stage_vld_i (stage_vld),
      .res_o (res), .vld_o (vld), .err_o (err)
   );

   function automatic int dig_of(logic [1:0] c);
      return (c == 2'b00) ? -1 : (c == 2'b10) ? 1 : 0;
   endfunction

   function automatic int exp_res(int s);
      int acc = 256;
      for (int k = 0; k < N; k++) acc += dig_of(code_a[s][k]) * (1 << (N - 1 - k));
      return acc;
   endfunction

   function automatic bit exp_vld(int s);
      bit v = 1'b1;
      for (int k = 0; k < N; k++) v &= sv_a[s][k];
      return v;
   endfunction

   function automatic bit exp_err(int s);
      bit e = 1'b0;
      for (int k = 0; k < N; k++) e |= (code_a[s][k] == 2'b11);
      return e & exp_vld(s);
   endfunction

   task automatic check(string req, int act, int expv, string what);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic set_sample(int s, logic [1:0] c, string t);
      for (int k = 0; k < N; k++) begin
         code_a[s][k] = c;
         sv_a[s][k]   = 1'b1;
      end
      tag_a[s] = t;
   endtask

   task automatic drive_cycle(int c);
      for (int k = 0; k < N; k++) begin
         int s = c - k;
         if (s >= 0 && s < NS) begin
            stage_code[2*k +: 2] = code_a[s][k];
            stage_vld[k]         = sv_a[s][k];
         end else begin
            stage_code[2*k +: 2] = 2'($urandom);
            stage_vld[k]         = 1'b0;
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int unsigned seed = $urandom(32'd20140901);
      seed = seed;
      // directed corner samples
      set_sample(0, 2'b10, "R4 all plus");
      set_sample(1, 2'b00, "R4 all minus");
      set_sample(2, 2'b01, "R4 all zero");
      for (int k = 0; k < N; k++) begin
         set_sample(3 + k, 2'b01, "R2 single weight");
         code_a[3 + k][k] = 2'b10;
      end
      set_sample(11, 2'b01, "R1 minus msb");
      code_a[11][0] = 2'b00;
      set_sample(12, 2'b10, "R7 illegal code");
      code_a[12][3] = 2'b11;
      set_sample(13, 2'b10, "R6 missing valid");
      sv_a[13][5] = 1'b0;
      // random back-to-back stream
      for (int s = 14; s < NS; s++) begin
         for (int k = 0; k < N; k++) begin
            code_a[s][k] = (($urandom % 16) == 0) ? 2'b11 : 2'($urandom % 3);
            sv_a[s][k]   = (($urandom % 24) != 0);
         end
         tag_a[s] = "R5 stream";
      end

      stage_code = '0;
      stage_vld  = '0;
      repeat (3) @(posedge clk);

      for (int c = 0; c < NS + 10; c++) begin
         int s;
         @(negedge clk);
         s = c - 9;
         if (c == 0) begin
            check("R8", int'(res), 0, "res after reset");
            check("R8", int'(vld), 0, "vld after reset");
            check("R8", int'(err), 0, "err after reset");
            rst = 1'b0;
         end else if (s < 0 || s >= NS) begin
            check("R6", int'(vld), 0, "vld without sample");
            check("R9", int'(err), 0, "err without sample");
         end else begin
            check(exp_vld(s) ? "R3" : "R6", int'(vld), int'(exp_vld(s)), tag_a[s]);
            check(exp_vld(s) ? "R7" : "R9", int'(err), int'(exp_err(s)), tag_a[s]);
            if (exp_vld(s)) check(exp_err(s) ? "R7" : "R1", int'(res), exp_res(s), tag_a[s]);
         end
         drive_cycle(c);
      end

      // steady full stream, then reset in the middle of it
      stage_code = {N{2'b10}};
      stage_vld  = '1;
      repeat (10) @(negedge clk);
      check("R5", int'(vld), 1, "steady stream vld");
      check("R4", int'(res), 511, "steady stream res");
      rst = 1'b1;
      @(negedge clk);
      check("R8", int'(vld), 0, "vld during reset");
      check("R8", int'(res), 0, "res during reset");
      rst = 1'b0;
      stage_vld = '0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         check("R8", int'(vld), 0, "in-flight sample after reset");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule